// File: doc/BRIEF.md
# Serial Link Unit Scheduler with Idle CRC

This block drives a serializer with an unbroken stream of fixed-length units, one byte per clock. At every unit boundary it decides what the next unit is. While the link is still synchronizing, it sends synchronization units. In data mode it sends a queued data unit if one is waiting. When nothing is waiting, it sends an idle unit. Software can also ask for a single marker ("yellow") unit. That request is remembered until it is served, and it outranks any waiting data.

Data units arrive whole, over a valid/ready handshake, into a one-unit holding stage. A unit held behind a yellow or sync unit stays in the holding stage, and the block drops ready until that unit has been sent. Each idle unit ends with a CRC-8 computed over its own preceding bytes, so the far end can check idle traffic too.

Top module: `lu_link_sched`

## Requirements
- R1: After reset the output carries one byte every cycle with no gaps. `out_first` is high on the first byte of each unit, and exactly once in every UNIT_LEN (default 10) consecutive cycles.
- R2: During reset and on the first unit after reset, the block emits a sync unit. `in_ready` is high.
- R3: When `sync_mode` is high in the last cycle of a unit, the next unit is a sync unit: every byte is 0xBC and `out_kind` = 0.
- R4: A data unit emits the held unit in order, with byte i taken from `in_unit[8i+7:8i]`, and `out_kind` = 2. It is chosen when the link is not in sync mode, no yellow request is pending, and the holding stage is full.
- R5: An idle unit is chosen when no other kind applies. It has `out_kind` = 1. Byte 0 is 0x1C. Byte 1 is an idle counter that starts at 0 after reset and increases by 1 for each idle unit. Bytes 2 to UNIT_LEN-2 are 0x00.
- R6: The last byte of an idle unit is the CRC-8 of bytes 0 to UNIT_LEN-2. The CRC uses polynomial 0x07, initial value 0x00, MSB first, with no final XOR.
- R7: A pulse on `yellow_req` in any cycle makes a yellow unit the next unit chosen outside sync mode. A yellow unit has every byte 0xA5 and `out_kind` = 3. It wins over waiting data. Requests made before it is served merge into one. A request in the deciding cycle itself is served at once.
- R8: `in_ready` is high exactly when the holding stage is empty. An accepted unit stays unchanged behind sync or yellow units, and the stage frees in the cycle its data unit starts.
- R9: The unit kind is chosen only at unit boundaries. Changes on `sync_mode` or `yellow_req` in the middle of a unit do not alter the unit in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | High while the link synchronization sequence runs |
| yellow_req | input | 1 | Single-cycle request for one yellow unit |
| in_valid | input | 1 | A data unit is offered on `in_unit` |
| in_ready | output | 1 | Holding stage is empty and can accept a unit |
| in_unit | input | UNIT_LEN*8 | Offered data unit, byte 0 in the low bits |
| out_byte | output | 8 | Byte sent to the serializer this cycle |
| out_first | output | 1 | High on the first byte of a unit |
| out_kind | output | 2 | Kind of current unit: 0 sync, 1 idle, 2 data, 3 yellow |

## Verification
A wrong byte counter shows up at `out_first` within one unit, as a first-byte marker at the wrong place. A lost or duplicated yellow flag shows up at the next boundary, either as a missing yellow unit or as an extra one. If the holding stage loses track of whether it is full, the effect is visible quickly: `in_ready` goes wrong in the next cycle, and the next boundary either drops a data unit or repeats one. A corrupt CRC register or idle counter only shows in idle bytes, so the stimulus keeps idle units frequent and compares every byte of every unit against a cycle-level model.

// File: rtl/lu_sched_pkg.sv
package lu_sched_pkg;

    typedef enum logic [1:0] {
        KIND_SYNC   = 2'd0,
        KIND_IDLE   = 2'd1,
        KIND_DATA   = 2'd2,
        KIND_YELLOW = 2'd3
    } unit_kind_e;

    localparam logic [7:0] SYNC_FILL   = 8'hBC;
    localparam logic [7:0] YELLOW_FILL = 8'hA5;
    localparam logic [7:0] IDLE_MARK   = 8'h1C;
    localparam logic [7:0] CRC_POLY    = 8'h07;

    // One byte of CRC-8, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] crc_in,
                                             input logic [7:0] din);
        logic [7:0] c;
        c = crc_in ^ din;
        for (int b = 0; b < 8; b++) begin
            if (c[7]) c = {c[6:0], 1'b0} ^ CRC_POLY;
            else      c = {c[6:0], 1'b0};
        end
        return c;
    endfunction

    // Content of byte position pos in an idle unit (last byte overridden by CRC).
    function automatic logic [7:0] idle_fill(input int pos, input logic [7:0] seq);
        if (pos == 0)      return IDLE_MARK;
        else if (pos == 1) return seq;
        else               return 8'h00;
    endfunction

endpackage

// File: rtl/lu_hold_stage.sv
module lu_hold_stage
    import lu_sched_pkg::*;
#(
    parameter int UNIT_W = 80
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [UNIT_W-1:0] in_unit,
    input  logic              take,
    output logic              in_ready,
    output logic              full,
    output logic [UNIT_W-1:0] held
);
    logic              full_q;
    logic [UNIT_W-1:0] held_q;
    logic              accept;

    assign accept   = in_valid && !full_q;
    assign in_ready = !full_q;
    assign full     = full_q;
    assign held     = held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            held_q <= '0;
        end else begin
            if (accept) begin
                full_q <= 1'b1;
                held_q <= in_unit;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    // R8: a waiting unit is neither lost nor altered until it is taken
    assert_hold_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (full_q && !take) |=> (full_q && $stable(held_q)));

    // R8: a take frees the stage
    assert_take_frees_R8: assert property (@(posedge clk) disable iff (rst)
        (full_q && take) |=> in_ready);

endmodule

// File: rtl/lu_pick.sv
module lu_pick
    import lu_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       at_edge,
    input  logic       sync_mode,
    input  logic       yellow_req,
    input  logic       data_avail,
    output unit_kind_e pick_kind,
    output logic       take,
    output logic [7:0] idle_seq
);
    logic       pend_q;
    logic       pend_eff;
    logic [7:0] seq_q;

    assign pend_eff = pend_q || yellow_req;
    assign idle_seq = seq_q;

    always_comb begin
        if (sync_mode)       pick_kind = KIND_SYNC;
        else if (pend_eff)   pick_kind = KIND_YELLOW;
        else if (data_avail) pick_kind = KIND_DATA;
        else                 pick_kind = KIND_IDLE;
    end

    assign take = at_edge && (pick_kind == KIND_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            seq_q  <= 8'h00;
        end else begin
            if (at_edge && pick_kind == KIND_YELLOW) pend_q <= 1'b0;
            else                                     pend_q <= pend_eff;
            if (at_edge && pick_kind == KIND_IDLE)   seq_q  <= seq_q + 8'd1;
        end
    end

    // R7: pending yellow blocks the data take at a boundary
    assert_yellow_beats_data_R7: assert property (@(posedge clk) disable iff (rst)
        (at_edge && !sync_mode && pend_q) |-> !take);

    // R7: serving the request clears the sticky flag
    assert_yellow_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (at_edge && !sync_mode && pend_q) |=> !pend_q);

    // R3: no data leaves during synchronization
    assert_sync_no_take_R3: assert property (@(posedge clk) disable iff (rst)
        sync_mode |-> !take);

endmodule

// File: rtl/lu_unit_crc.sv
module lu_unit_crc
    import lu_sched_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [7:0] byte_in,
    output logic [7:0] crc
);
    logic [7:0] crc_q;

    assign crc = crc_q;

    always_ff @(posedge clk) begin
        if (rst || restart) crc_q <= 8'h00;
        else                crc_q <= crc8_step(crc_q, byte_in);
    end

    // R6: each unit starts its CRC from the initial value
    assert_crc_restart_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (crc_q == 8'h00));

endmodule

// File: rtl/lu_link_sched.sv
module lu_link_sched
    import lu_sched_pkg::*;
#(
    parameter int UNIT_LEN = 10
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sync_mode,
    input  logic                  yellow_req,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [UNIT_LEN*8-1:0] in_unit,
    output logic [7:0]            out_byte,
    output logic                  out_first,
    output logic [1:0]            out_kind
);
    localparam int UNIT_W = UNIT_LEN * 8;
    localparam int IDX_W  = (UNIT_LEN > 2) ? $clog2(UNIT_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(UNIT_LEN - 1);

    logic [IDX_W-1:0] idx_q;
    unit_kind_e       kind_q;
    logic [7:0]       unit_q   [UNIT_LEN];
    logic [7:0]       unit_nxt [UNIT_LEN];
    logic             at_edge;
    unit_kind_e       pick_kind;
    logic             take;
    logic             full;
    logic [UNIT_W-1:0] held;
    logic [7:0]       idle_seq;
    logic [7:0]       crc;
    logic [7:0]       byte_mux;

    assign at_edge = (idx_q == LAST_IDX);

    lu_hold_stage #(.UNIT_W(UNIT_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_unit  (in_unit),
        .take     (take),
        .in_ready (in_ready),
        .full     (full),
        .held     (held)
    );

    lu_pick u_pick (
        .clk        (clk),
        .rst        (rst),
        .at_edge    (at_edge),
        .sync_mode  (sync_mode),
        .yellow_req (yellow_req),
        .data_avail (full),
        .pick_kind  (pick_kind),
        .take       (take),
        .idle_seq   (idle_seq)
    );

    lu_unit_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .restart (at_edge),
        .byte_in (byte_mux),
        .crc     (crc)
    );

    // Next-unit content per byte position, chosen by the picked kind.
    for (genvar gi = 0; gi < UNIT_LEN; gi++) begin : g_fill
        always_comb begin
            unique case (pick_kind)
                KIND_SYNC:   unit_nxt[gi] = SYNC_FILL;
                KIND_YELLOW: unit_nxt[gi] = YELLOW_FILL;
                KIND_DATA:   unit_nxt[gi] = held[8*gi +: 8];
                default:     unit_nxt[gi] = idle_fill(gi, idle_seq);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            kind_q <= KIND_SYNC;
            for (int i = 0; i < UNIT_LEN; i++) unit_q[i] <= SYNC_FILL;
        end else if (at_edge) begin
            idx_q  <= '0;
            kind_q <= pick_kind;
            for (int i = 0; i < UNIT_LEN; i++) unit_q[i] <= unit_nxt[i];
        end else begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    always_comb begin
        if (kind_q == KIND_IDLE && at_edge) byte_mux = crc;
        else                                byte_mux = unit_q[idx_q];
    end

    assign out_byte  = byte_mux;
    assign out_first = (idx_q == '0);
    assign out_kind  = kind_q;

    // R9: kind only changes on a first byte
    assert_kind_steady_R9: assert property (@(posedge clk) disable iff (rst)
        !out_first |-> $stable(out_kind));

    // R1: two first bytes never sit back to back
    assert_first_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        out_first |=> !out_first);

    // R3: sync at the deciding cycle yields a sync unit
    assert_sync_pick_R3: assert property (@(posedge clk) disable iff (rst)
        (at_edge && sync_mode) |=> (out_kind == 2'd0));

    initial begin
        assert_unit_len_R1: assert (UNIT_LEN >= 3);
    end

endmodule

// File: tb/lu_link_sched_bench.sv
module lu_link_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int L = 10;
    localparam int N_CYC = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode = 1'b1;
    logic yellow_req = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [L*8-1:0] in_unit = '0;
    logic [7:0] out_byte;
    logic out_first;
    logic [1:0] out_kind;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lu_link_sched #(.UNIT_LEN(L)) u_lu_link_sched (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .yellow_req(yellow_req),
        .in_valid(in_valid), .in_ready(in_ready), .in_unit(in_unit),
        .out_byte(out_byte), .out_first(out_first), .out_kind(out_kind)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] b [L]);
        logic [7:0] r;
        r = 8'h00;
        for (int k = 0; k < L-1; k++) begin
            r = r ^ b[k];
            for (int j = 0; j < 8; j++)
                r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        end
        return r;
    endfunction

    // Cycle-level reference built from the requirements
    int         m_idx;
    int         m_kind;
    logic [7:0] m_bytes [L];
    bit         m_full;
    logic [L*8-1:0] m_buf;
    bit         m_pend;
    logic [7:0] m_seq;
    bit         m_acc;

    always @(posedge clk) begin
        bit pe, tk;
        if (rst) begin
            m_idx = 0; m_kind = 0; m_full = 0; m_pend = 0; m_seq = 0; m_acc = 0;
            m_buf = '0;
            for (int i = 0; i < L; i++) m_bytes[i] = 8'hBC;
        end else begin
            m_acc = in_valid && !m_full;
            pe = m_pend || yellow_req;
            tk = 0;
            if (m_idx == L-1) begin
                m_idx = 0;
                if (sync_mode) begin
                    m_kind = 0; m_pend = pe;
                    for (int i = 0; i < L; i++) m_bytes[i] = 8'hBC;
                end else if (pe) begin
                    m_kind = 3; m_pend = 0;
                    for (int i = 0; i < L; i++) m_bytes[i] = 8'hA5;
                end else if (m_full) begin
                    m_kind = 2; m_pend = 0; tk = 1;
                    for (int i = 0; i < L; i++) m_bytes[i] = m_buf[8*i +: 8];
                end else begin
                    m_kind = 1; m_pend = 0;
                    for (int i = 0; i < L; i++) m_bytes[i] = 8'h00;
                    m_bytes[0] = 8'h1C; m_bytes[1] = m_seq;
                    m_seq = m_seq + 8'd1;
                end
            end else begin
                m_idx = m_idx + 1;
                m_pend = pe;
            end
            if (tk) m_full = 0;
            if (m_acc) begin m_full = 1; m_buf = in_unit; end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        logic [7:0] eb;
        string tag;
        eb = m_bytes[m_idx];
        case (m_kind)
            0: tag = "R3";
            1: tag = "R5";
            2: tag = "R4";
            default: tag = "R7";
        endcase
        if (m_kind == 1 && m_idx == L-1) begin
            eb = ref_crc(m_bytes);
            tag = "R6";
        end
        chk(out_byte == eb, tag, "out_byte", out_byte, eb);
        chk(out_first == (m_idx == 0), "R1", "out_first", out_first, m_idx == 0);
        chk(out_kind == m_kind[1:0], (m_idx == 0) ? tag : "R9", "out_kind",
            out_kind, m_kind);
        chk(in_ready == !m_full, "R8", "in_ready", in_ready, !m_full);
    endtask

    task automatic new_unit();
        for (int i = 0; i < L; i++) in_unit[8*i +: 8] = 8'($urandom);
    endtask

    initial begin
        int rate;
        int sync_left;
        void'($urandom(32'd20240611));
        sync_left = 0;
        @(negedge clk); @(negedge clk);
        // Reset state (R2)
        chk(out_first == 1'b1, "R2", "reset out_first", out_first, 1);
        chk(out_kind == 2'd0, "R2", "reset out_kind", out_kind, 0);
        chk(out_byte == 8'hBC, "R2", "reset out_byte", out_byte, 8'hBC);
        chk(in_ready == 1'b1, "R2", "reset in_ready", in_ready, 1);
        rst = 1'b0;
        for (int n = 0; n < N_CYC; n++) begin
            @(negedge clk);
            compare_outputs();
            // first unit after reset must be sync (R2)
            if (n == 0) chk(out_kind == 2'd0, "R2", "first unit kind", out_kind, 0);
            // sync mode
            if (n < 60) sync_mode = 1'b1;
            else if (sync_left > 0) begin sync_mode = 1'b1; sync_left--; end
            else begin
                sync_mode = 1'b0;
                if ($urandom_range(0, 299) == 0) sync_left = $urandom_range(5, 30);
            end
            // yellow requests: directed merge, held-in-sync, then random
            if (n == 20 || n == 203 || n == 206 || n == 207 || n == 1504)
                yellow_req = 1'b1;
            else
                yellow_req = ($urandom_range(0, 59) == 0);
            // data offers with changing load
            if (n < 1000)      rate = 90;
            else if (n < 2000) rate = 10;
            else if (n < 3000) rate = 100;
            else               rate = 50;
            if (!in_valid || m_acc) begin
                in_valid = ($urandom_range(0, 99) < rate);
                if (in_valid) new_unit();
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule